// File: doc/BRIEF.md
# Processor Mode Control Register

This unit holds the 8-bit processor-mode control register of a small microcontroller. The two lowest bits form the mode field: 00b single-chip, 01b memory expansion, 10b reserved, 11b microprocessor. The upper six bits are general control bits. While reset is active, the unit samples the mode-select pin and loads the mode field from it. It also records whether that reset was taken with the pin high. A record set this way keeps the internal ROM shut off until a later reset is taken with the pin low.

Software writes a whole byte through a strobed write port. A second input states whether the writing instruction was fetched from internal ROM space. The control half checks each write against the mode-change protection rules and tells the datapath half, through two strobes, whether to load the upper bits and whether to load the mode field. The current mode, the internal ROM enable and a readback of the register are driven straight from the stored state.

Top module: `procModeCtl`

## Requirements
- R1: When a reset is taken with `modePin` low, the register reads 0x00 (mode 00b) and `romEn` is 1 on the first cycle after reset.
- R2: When a reset is taken with `modePin` high, the register reads 0x03 (mode 11b) and `romEn` is 0.
- R3: A reset through `bodRst` (active high) gives the same result as a reset through `rstN`: the mode and the ROM-disable record both come from `modePin`.
- R4: Outside reset, a permitted write loads `wrData` whatever level `modePin` has. The new value appears on `regRd` and `mode` after the first rising edge that samples `wrEn` high.
- R5: A write with mode field 01b or 11b whose bits 7..2 differ from the stored bits 7..2 is discarded completely. The register keeps its whole previous value.
- R6: A write that would move the mode from a value other than 11b to 11b while `fetchInRom` is 1 leaves the mode unchanged. Bits 7..2 are still written.
- R7: A write that would move the mode from 11b to another value while `fetchInRom` is 1 leaves the mode unchanged. Bits 7..2 are still written.
- R8: A write of the reserved value 10b leaves the mode unchanged. Bits 7..2 are still written.
- R9: `romEn` is 1 in modes 00b and 01b and 0 in mode 11b. After a pin-high reset it stays 0 in every mode until a reset is taken with the pin low.
- R10: With `wrEn` low, the register holds its value whatever `wrData` and `fetchInRom` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Hardware reset, active low, synchronous |
| bodRst | input | 1 | Brown-out reset cause, active high, synchronous |
| modePin | input | 1 | Mode-select pin, sampled while reset is active |
| wrEn | input | 1 | Write strobe for the register |
| wrData | input | 8 | Byte written to the register |
| fetchInRom | input | 1 | Writing instruction was fetched from internal ROM space |
| mode | output | 2 | Current processor mode field |
| romEn | output | 1 | Internal ROM access enable |
| regRd | output | 8 | Current register contents |

## Verification
Every write result is due one rising edge after the strobe, because the control half is purely combinational and the datapath holds a single register stage. The bench drives the inputs on a falling edge and checks `regRd`, `mode` and `romEn` on the next falling edge. Reset results are checked on the first falling edge after reset is released. `romEn` is checked in the same window as the mode, because it is decoded without a further register from the stored mode and the stored pin-high record.

// File: rtl/procModePkg.sv
package procModePkg;
  localparam int REG_W  = 8;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_SINGLE = 2'b00,
    MODE_EXPAND = 2'b01,
    MODE_RSVD   = 2'b10,
    MODE_MICRO  = 2'b11
  } modeT;

  // Strobes from the write filter to the register datapath
  typedef struct packed {
    logic wrUpper;
    logic wrMode;
  } wrStrobeT;
endpackage

// File: rtl/procModeCtlFilter.sv
module procModeCtlFilter
  import procModePkg::*;
#(
  parameter int REG_W  = procModePkg::REG_W,
  parameter int MODE_W = procModePkg::MODE_W
) (
  input  logic                    clk,
  input  logic                    rstAny,
  input  logic                    wrEn,
  input  logic [REG_W-1:0]        wrData,
  input  logic                    fetchInRom,
  input  logic [MODE_W-1:0]       curMode,
  input  logic [REG_W-MODE_W-1:0] curUpper,
  output wrStrobeT                strobe
);
  logic [MODE_W-1:0] newMode;
  logic upperChg, bigMode, discardAll, rsvdMode, enterBlk, leaveBlk;

  always_comb begin
    newMode    = wrData[MODE_W-1:0];
    upperChg   = wrData[REG_W-1:MODE_W] != curUpper;
    bigMode    = (newMode == MODE_EXPAND) || (newMode == MODE_MICRO);
    discardAll = bigMode && upperChg;
    rsvdMode   = newMode == MODE_RSVD;
    enterBlk   = fetchInRom && (newMode == MODE_MICRO) && (curMode != MODE_MICRO);
    leaveBlk   = fetchInRom && (curMode == MODE_MICRO) && (newMode != MODE_MICRO);
    strobe.wrUpper = wrEn && !discardAll;
    strobe.wrMode  = wrEn && !discardAll && !rsvdMode && !enterBlk && !leaveBlk;
  end

  // R5
  property pDiscard;
    @(posedge clk) disable iff (rstAny)
      (wrEn && (wrData[1:0] == 2'b01 || wrData[1:0] == 2'b11) &&
       wrData[REG_W-1:MODE_W] != curUpper)
      |=> ($stable(curMode) && $stable(curUpper));
  endproperty
  discard_whole_chk: assert property (pDiscard);

  // R6
  property pEnterRom;
    @(posedge clk) disable iff (rstAny)
      (wrEn && fetchInRom && wrData[1:0] == 2'b11 && curMode != 2'b11) |=> curMode != 2'b11;
  endproperty
  no_enter_micro_chk: assert property (pEnterRom);

  // R7
  property pLeaveRom;
    @(posedge clk) disable iff (rstAny)
      (wrEn && fetchInRom && curMode == 2'b11 && wrData[1:0] != 2'b11) |=> curMode == 2'b11;
  endproperty
  no_leave_micro_chk: assert property (pLeaveRom);

  // R8
  property pRsvd;
    @(posedge clk) disable iff (rstAny)
      (wrEn && wrData[1:0] == 2'b10) |=> $stable(curMode);
  endproperty
  rsvd_ignored_chk: assert property (pRsvd);

  // R10
  property pHold;
    @(posedge clk) disable iff (rstAny)
      !wrEn |=> ($stable(curMode) && $stable(curUpper));
  endproperty
  hold_idle_chk: assert property (pHold);
endmodule

// File: rtl/procModeDp.sv
module procModeDp
  import procModePkg::*;
#(
  parameter int REG_W  = procModePkg::REG_W,
  parameter int MODE_W = procModePkg::MODE_W
) (
  input  logic                    clk,
  input  logic                    rstAny,
  input  logic                    modePin,
  input  logic [REG_W-1:0]        wrData,
  input  wrStrobeT                strobe,
  output logic [MODE_W-1:0]       curMode,
  output logic [REG_W-MODE_W-1:0] curUpper,
  output logic                    romEn,
  output logic [REG_W-1:0]        regRd
);
  localparam int UP_W = REG_W - MODE_W;

  logic [MODE_W-1:0] modeQ;
  logic [UP_W-1:0]   upperQ;
  logic              pinHighRst;

  always_ff @(posedge clk) begin
    if (rstAny) begin
      modeQ      <= modePin ? MODE_MICRO : MODE_SINGLE;
      upperQ     <= '0;
      pinHighRst <= modePin;
    end else begin
      if (strobe.wrMode)  modeQ  <= wrData[MODE_W-1:0];
      if (strobe.wrUpper) upperQ <= wrData[REG_W-1:MODE_W];
    end
  end

  always_comb begin
    curMode  = modeQ;
    curUpper = upperQ;
    regRd    = {upperQ, modeQ};
    romEn    = !pinHighRst && (modeQ != MODE_MICRO);
  end

  // R1 R2 R3
  property pRstMode;
    @(posedge clk) rstAny |=> (curMode == ($past(modePin) ? 2'b11 : 2'b00)) && (curUpper == '0);
  endproperty
  reset_mode_chk: assert property (pRstMode);

  // R9
  property pRomMicro;
    @(posedge clk) disable iff (rstAny) romEn |-> curMode != 2'b11;
  endproperty
  rom_off_micro_chk: assert property (pRomMicro);

  // R9
  property pRomLatch;
    @(posedge clk) disable iff (rstAny) (!romEn && curMode != 2'b11) |=> !romEn;
  endproperty
  rom_latch_chk: assert property (pRomLatch);
endmodule

// File: rtl/procModeCtl.sv
module procModeCtl
  import procModePkg::*;
#(
  parameter int REG_W  = procModePkg::REG_W,
  parameter int MODE_W = procModePkg::MODE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bodRst,
  input  logic              modePin,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  input  logic              fetchInRom,
  output logic [MODE_W-1:0] mode,
  output logic              romEn,
  output logic [REG_W-1:0]  regRd
);
  localparam int UP_W = REG_W - MODE_W;

  logic              rstAny;
  wrStrobeT          strobe;
  logic [MODE_W-1:0] curMode;
  logic [UP_W-1:0]   curUpper;

  assign rstAny = !rstN || bodRst;
  assign mode   = curMode;

  procModeCtlFilter #(.REG_W(REG_W), .MODE_W(MODE_W)) u_filter (
    .clk(clk), .rstAny(rstAny), .wrEn(wrEn), .wrData(wrData),
    .fetchInRom(fetchInRom), .curMode(curMode), .curUpper(curUpper),
    .strobe(strobe)
  );

  procModeDp #(.REG_W(REG_W), .MODE_W(MODE_W)) u_dp (
    .clk(clk), .rstAny(rstAny), .modePin(modePin), .wrData(wrData),
    .strobe(strobe), .curMode(curMode), .curUpper(curUpper),
    .romEn(romEn), .regRd(regRd)
  );
endmodule

// File: tb/procModeCtl_tb.sv
`timescale 1ns/1ps
module procModeCtl_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0, bodRst = 1'b0, modePin = 1'b0;
  logic wrEn = 1'b0, fetchInRom = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [1:0] mode;
  logic romEn;
  logic [7:0] regRd;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  procModeCtl u_dut (
    .clk(clk), .rstN(rstN), .bodRst(bodRst), .modePin(modePin),
    .wrEn(wrEn), .wrData(wrData), .fetchInRom(fetchInRom),
    .mode(mode), .romEn(romEn), .regRd(regRd)
  );

  // {wrData, fetchInRom, expected regRd, expected romEn, requirement}
  localparam int NV = 12;
  localparam logic [21:0] VEC [NV] = '{
    {8'h01, 1'b0, 8'h01, 1'b1, 4'd4},  // R4 enter expansion
    {8'h00, 1'b1, 8'h00, 1'b1, 4'd4},  // R4 leave expansion from ROM is allowed
    {8'h05, 1'b0, 8'h00, 1'b1, 4'd5},  // R5 upper change with 01b
    {8'h04, 1'b0, 8'h04, 1'b1, 4'd4},  // R4 upper change with 00b
    {8'h07, 1'b1, 8'h04, 1'b1, 4'd6},  // R6 enter micro from ROM
    {8'h0A, 1'b0, 8'h08, 1'b1, 4'd8},  // R8 reserved, upper written
    {8'h0B, 1'b0, 8'h0B, 1'b0, 4'd9},  // R9 micro turns ROM off
    {8'h08, 1'b1, 8'h0B, 1'b0, 4'd7},  // R7 leave micro from ROM
    {8'h10, 1'b1, 8'h13, 1'b0, 4'd7},  // R7 upper still written
    {8'h11, 1'b0, 8'h11, 1'b1, 4'd9},  // R9 leave micro, ROM on
    {8'h12, 1'b0, 8'h11, 1'b1, 4'd8},  // R8 reserved ignored
    {8'h13, 1'b1, 8'h11, 1'b1, 4'd6}   // R6 refused again
  };

  task automatic check(input string req, input logic [7:0] expRd, input logic expRom);
    checks++;
    if (regRd !== expRd || romEn !== expRom || mode !== expRd[1:0]) begin
      errors++;
      $display("FAIL %s: regRd=%h mode=%b romEn=%b expected regRd=%h mode=%b romEn=%b",
               req, regRd, mode, romEn, expRd, expRd[1:0], expRom);
    end
  endtask

  task automatic doWrite(input logic [7:0] d, input logic rom);
    @(negedge clk);
    wrEn = 1'b1; wrData = d; fetchInRom = rom;
    @(negedge clk);
    wrEn = 1'b0; fetchInRom = 1'b0;
  endtask

  task automatic doReset(input logic useBod, input logic pin);
    @(negedge clk);
    modePin = pin;
    if (useBod) bodRst = 1'b1; else rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1; bodRst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    modePin = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", 8'h00, 1'b1);

    for (int i = 0; i < NV; i++) begin
      doWrite(VEC[i][21:14], VEC[i][13]);
      check($sformatf("R%0d", VEC[i][3:0]), VEC[i][12:5], VEC[i][4]);
    end

    // R2 pin-high reset
    doReset(1'b0, 1'b1);
    check("R2", 8'h03, 1'b0);
    // R9 ROM stays off after pin-high reset in single-chip mode
    doWrite(8'h00, 1'b0);
    check("R9", 8'h00, 1'b0);
    // R4 write works regardless of pin level (pin still high)
    doWrite(8'h01, 1'b0);
    check("R4", 8'h01, 1'b0);
    // R10 no strobe: data and ROM flag toggle without effect
    @(negedge clk);
    wrData = 8'hFF; fetchInRom = 1'b1;
    @(negedge clk);
    wrData = 8'h00; fetchInRom = 1'b0;
    @(negedge clk);
    check("R10", 8'h01, 1'b0);
    // R3 brown-out reset with pin low clears the ROM-off record
    doReset(1'b1, 1'b0);
    check("R3", 8'h00, 1'b1);
    // R3 brown-out reset with pin high
    doReset(1'b1, 1'b1);
    check("R3", 8'h03, 1'b0);
    // R1 hardware reset with pin low clears the record
    doReset(1'b0, 1'b0);
    check("R1", 8'h00, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule